// File: doc/BRIEF.md
# Bit-Masked Control Register Bank for a Storage PHY

This block holds the control state of a storage-interface PHY wrapper behind a small synchronous register bus. Seven 16-bit control registers sit at word-aligned byte offsets 0x00 to 0x18, and one read-only status register sits at 0x20. Every write word carries its own enable mask in its upper half. Low bit x of the target register changes only when bit x+16 of the same word is 1. Software can therefore set or clear one field, such as the power-up bit or the DLL enable, without first reading the register back.

The stored bits that control the PHY leave the block as named field ports. These are power-up, DLL enable, drive-strength code, DLL frequency band, output tap enable and output tap select. The calibration-done and DLL-ready status inputs are sampled when software reads the status register. Reads are registered: read data appears on the cycle after the read strobe and is zero on any other cycle.

Top module: `phyreg_bank`

## Requirements
- R1: On a write to a control register, stored bit x (x = 0..15) takes wdata bit x only when wdata bit x+16 is 1. Every other stored bit keeps its value, and with no write no stored bit changes.
- R2: The upper 16 bits of a write are never stored, and rdata bits 31:16 are always zero.
- R3: The control registers are at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 (index = offset/4). Each one stores and reads back all 16 low bits.
- R4: Register 0x18 drives the fields pwr_on_o (bit 0, 1 = powered), dll_en_o (bit 1) and drive_code_o (bits 6:4).
- R5: Register 0x00 drives the fields freq_band_o (bits 13:12), otap_en_o (bit 11) and otap_sel_o (bits 10:7).
- R6: A read of offset 0x20 returns cal_done_i in bit 6 and dll_ready_i in bit 5, both sampled in the read-strobe cycle. All other bits of that read are zero.
- R7: Writes to offset 0x20 and to unmapped offsets change no stored bit. Unmapped offsets are 0x1C, any offset above 0x20 and any offset whose low two bits are not zero.
- R8: Reset clears every control bit, so the PHY starts powered down with the DLL disabled.
- R9: rdata is registered. It carries the read value on the cycle after rd_en and is zero after a cycle without rd_en. A read and a write to the same register in one cycle return the value from before the write.
- R10: A read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write word: enable mask in 31:16, data in 15:0 |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration done status |
| dll_ready_i | input | 1 | DLL ready status |
| pwr_on_o | output | 1 | PHY power-up control |
| dll_en_o | output | 1 | DLL enable |
| drive_code_o | output | 3 | Drive-strength code |
| freq_band_o | output | 2 | DLL frequency band select |
| otap_en_o | output | 1 | Output tap delay enable |
| otap_sel_o | output | 4 | Output tap delay select |

## Verification
The assertions assume that the status inputs are synchronous to clk and that the bus strobes are held low during reset. The bench drives all of these signals one time unit after the rising edge and keeps both strobes low while rst_n is low. No assumption is made about how read and write strobes combine, so the stimulus includes cycles that read and write the same register at once. The stimulus also writes to the status offset, to the hole at 0x1C, to misaligned offsets and to offsets beyond the map, using full masks and upper halves that are all ones.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;

  // Status bit positions
  localparam int unsigned CAL_BIT = 6;
  localparam int unsigned DLL_BIT = 5;

  // Field map: slot index and bit positions
  localparam int unsigned PWR_SLOT   = 6;
  localparam int unsigned PWR_BIT    = 0;
  localparam int unsigned DLLEN_BIT  = 1;
  localparam int unsigned DRV_LSB    = 4;
  localparam int unsigned DRV_W      = 3;
  localparam int unsigned TAP_SLOT   = 0;
  localparam int unsigned BAND_LSB   = 12;
  localparam int unsigned BAND_W     = 2;
  localparam int unsigned TAPEN_BIT  = 11;
  localparam int unsigned TAPSEL_LSB = 7;
  localparam int unsigned TAPSEL_W   = 4;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  // Merge the low-half data into the old value wherever the upper-half mask is set
  function automatic half_t masked_merge(input half_t old_v, input word_t word);
    half_t mask;
    half_t data;
    mask = word[WORD_W-1:HALF_W];
    data = word[HALF_W-1:0];
    return (old_v & ~mask) | (data & mask);
  endfunction

  // Status word assembled from the two sampled inputs
  function automatic half_t status_word(input logic cal, input logic dll);
    half_t s;
    s = '0;
    s[CAL_BIT] = cal;
    s[DLL_BIT] = dll;
    return s;
  endfunction

endpackage

// File: rtl/phyreg_decode.sv
module phyreg_decode #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned N_CTRL     = 7,
  parameter int unsigned STATUS_OFF = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_CTRL-1:0] ctrl_sel,
  output logic              stat_sel
);
  genvar k;
  generate
    for (k = 0; k < N_CTRL; k++) begin : g_sel
      assign ctrl_sel[k] = (addr == ADDR_W'(k * 4));
    end
  endgenerate

  assign stat_sel = (addr == ADDR_W'(STATUS_OFF));
endmodule

// File: rtl/phyreg_slot.sv
module phyreg_slot
  import phyreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  word_t word,
  output half_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= masked_merge(q, word);
  end
endmodule

// File: rtl/phyreg_rdmux.sv
module phyreg_rdmux
  import phyreg_pkg::*;
#(
  parameter int unsigned N_CTRL = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [N_CTRL-1:0]        ctrl_sel,
  input  logic                     stat_sel,
  input  logic [N_CTRL*HALF_W-1:0] ctrl_flat,
  input  half_t                    stat_val,
  output word_t                    rdata
);
  half_t sel_val;

  always_comb begin
    sel_val = stat_sel ? stat_val : '0;
    for (int k = 0; k < N_CTRL; k++) begin
      if (ctrl_sel[k]) sel_val = sel_val | ctrl_flat[k*HALF_W +: HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= {{HALF_W{1'b0}}, sel_val};
    else            rdata <= '0;
  end
endmodule

// File: rtl/phyreg_bank.sv
module phyreg_bank
  import phyreg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned N_CTRL     = 7,
  parameter int unsigned STATUS_OFF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [31:0]       rdata_o,
  input  logic              cal_done_i,
  input  logic              dll_ready_i,
  output logic              pwr_on_o,
  output logic              dll_en_o,
  output logic [2:0]        drive_code_o,
  output logic [1:0]        freq_band_o,
  output logic              otap_en_o,
  output logic [3:0]        otap_sel_o
);
  localparam int unsigned FLAT_W = N_CTRL * HALF_W;

  logic [N_CTRL-1:0] ctrl_sel;
  logic              stat_sel;
  logic [FLAT_W-1:0] ctrl_flat;
  logic              wr_hit_ctrl;
  half_t             stat_val;
  half_t             pwr_reg;
  half_t             tap_reg;

  phyreg_decode #(.ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .STATUS_OFF(STATUS_OFF)) u_dec (
    .addr(addr_i), .ctrl_sel(ctrl_sel), .stat_sel(stat_sel)
  );

  assign wr_hit_ctrl = wr_en_i & (|ctrl_sel);

  genvar k;
  generate
    for (k = 0; k < N_CTRL; k++) begin : g_slot
      phyreg_slot u_slot (
        .clk(clk), .rst_n(rst_n), .we(wr_en_i & ctrl_sel[k]),
        .word(wdata_i), .q(ctrl_flat[k*HALF_W +: HALF_W])
      );
    end
  endgenerate

  assign stat_val = status_word(cal_done_i, dll_ready_i);

  phyreg_rdmux #(.N_CTRL(N_CTRL)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en_i), .ctrl_sel(ctrl_sel),
    .stat_sel(stat_sel), .ctrl_flat(ctrl_flat), .stat_val(stat_val), .rdata(rdata_o)
  );

  // Field outputs
  assign pwr_reg      = ctrl_flat[PWR_SLOT*HALF_W +: HALF_W];
  assign tap_reg      = ctrl_flat[TAP_SLOT*HALF_W +: HALF_W];
  assign pwr_on_o     = pwr_reg[PWR_BIT];
  assign dll_en_o     = pwr_reg[DLLEN_BIT];
  assign drive_code_o = pwr_reg[DRV_LSB +: DRV_W];
  assign freq_band_o  = tap_reg[BAND_LSB +: BAND_W];
  assign otap_en_o    = tap_reg[TAPEN_BIT];
  assign otap_sel_o   = tap_reg[TAPSEL_LSB +: TAPSEL_W];
endmodule

// File: rtl/phyreg_bank_chk.sv
module phyreg_bank_chk #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned N_CTRL     = 7,
  parameter int unsigned STATUS_OFF = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [31:0]          wdata_i,
  input logic                 wr_en_i,
  input logic                 rd_en_i,
  input logic [31:0]          rdata_o,
  input logic                 cal_done_i,
  input logic                 dll_ready_i,
  input logic [N_CTRL*16-1:0] ctrl_flat,
  input logic                 wr_hit_ctrl
);
  logic        in_map;
  logic        unmapped;
  int unsigned slot;
  logic        pend_q;
  int unsigned slot_q;
  logic [15:0] exp_q;
  logic        was_rst_q;

  assign slot     = int'(addr_i) / 4;
  assign in_map   = (addr_i[1:0] == 2'b00) && (slot < N_CTRL);
  assign unmapped = !in_map && (addr_i != ADDR_W'(STATUS_OFF));

  always_ff @(posedge clk) begin
    was_rst_q <= !rst_n;
    pend_q    <= rst_n && wr_en_i && in_map;
    slot_q    <= slot;
    if (in_map) begin
      exp_q <= ctrl_flat[slot*16 +: 16] ^
               ((ctrl_flat[slot*16 +: 16] ^ wdata_i[15:0]) & wdata_i[31:16]);
    end
  end

  always_ff @(posedge clk) begin
    if (was_rst_q && rst_n) begin
      AST_RESET_CLEAR: assert (ctrl_flat == '0); // R8
    end
    if (rst_n && pend_q) begin
      AST_MASKED_UPDATE: assert (ctrl_flat[slot_q*16 +: 16] == exp_q); // R1
    end
  end

  AST_HIT_MATCHES_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_ctrl == (wr_en_i && in_map)); // R3

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(ctrl_flat)); // R1

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !in_map) |=> $stable(ctrl_flat)); // R7

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[31:16] == 16'h0); // R2

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_W'(STATUS_OFF)) |=>
      (rdata_o == ({25'd0, $past(cal_done_i), $past(dll_ready_i), 5'd0}))); // R6

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && unmapped) |=> rdata_o == 32'h0); // R10

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> rdata_o == 32'h0); // R9
endmodule

bind phyreg_bank phyreg_bank_chk #(.ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .STATUS_OFF(STATUS_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .rdata_o(rdata_o), .cal_done_i(cal_done_i), .dll_ready_i(dll_ready_i),
  .ctrl_flat(ctrl_flat), .wr_hit_ctrl(wr_hit_ctrl)
);

// File: tb/phyreg_bank_tb.sv
module phyreg_bank_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] rdata;
  logic        cal = 0, dll = 0;
  logic        pwr_on, dll_en, otap_en;
  logic [2:0]  drv;
  logic [1:0]  band;
  logic [3:0]  tsel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int unsigned model [7];
  logic [31:0] exp_rd;

  always #2 clk = ~clk;

  phyreg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .rdata_o(rdata), .cal_done_i(cal), .dll_ready_i(dll),
    .pwr_on_o(pwr_on), .dll_en_o(dll_en), .drive_code_o(drv), .freq_band_o(band),
    .otap_en_o(otap_en), .otap_sel_o(tsel)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_read(input logic [7:0] a);
    if (a[1:0] == 0 && a < 8'h1C) return model[a / 4];
    if (a == 8'h20) return (cal ? 32'd64 : 32'd0) + (dll ? 32'd32 : 32'd0);
    return 0;
  endfunction

  task automatic ref_write(input logic [7:0] a, input logic [31:0] d);
    if (a[1:0] == 0 && a < 8'h1C) begin
      for (int b = 0; b < 16; b++)
        if (d[b + 16]) begin
          if (d[b]) model[a / 4] = model[a / 4] | (1 << b);
          else      model[a / 4] = model[a / 4] & ~(1 << b);
        end
    end
  endtask

  task automatic check_fields();
    check("R4 pwr_on",     pwr_on, model[6] & 1);
    check("R4 dll_en",     dll_en, (model[6] >> 1) & 1);
    check("R4 drive_code", drv,    (model[6] >> 4) & 7);
    check("R5 freq_band",  band,   (model[0] >> 12) & 3);
    check("R5 otap_en",    otap_en,(model[0] >> 11) & 1);
    check("R5 otap_sel",   tsel,   (model[0] >> 7) & 15);
  endtask

  // One bus cycle: drive, advance model, compare after the edge
  task automatic cyc(input logic [7:0] a, input logic [31:0] d,
                     input bit we, input bit re, input string tag);
    addr = a; wdata = d; wr_en = we; rd_en = re;
    exp_rd = re ? ref_read(a) : 32'h0;
    if (we) ref_write(a, d);
    @(posedge clk); #1;
    check(tag, rdata, exp_rd);
    check_fields();
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(a, d, 1, 0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(a, 0, 0, 1, tag);
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rd_en = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 7; i++) model[i] = 0;
  endtask

  initial begin
    for (int i = 0; i < 7; i++) model[i] = 32'h5A5A;
    do_reset();
    // R8: everything cleared after reset
    check_fields();
    for (int i = 0; i < 7; i++) rd(8'(i * 4), "R8 reset read");

    // R4: power, DLL enable and drive code fields, one at a time
    wr(8'h18, 32'h0001_0001, "R4");
    wr(8'h18, 32'h0002_0002, "R4");
    wr(8'h18, 32'h0070_FFD5, "R4");
    rd(8'h18, "R4 readback");
    wr(8'h18, 32'h0001_0000, "R4");
    rd(8'h18, "R4 readback");

    // R1: only masked bits change
    wr(8'h00, 32'h00F0_FFFF, "R1");
    rd(8'h00, "R1 partial mask");
    wr(8'h04, 32'hFFFF_A5C3, "R1");
    wr(8'h04, 32'h0F00_0000, "R1");
    rd(8'h04, "R1 masked clear");
    wr(8'h04, 32'h0000_FFFF, "R1");
    rd(8'h04, "R1 zero mask");
    wr(8'h08, 32'h8001_8001, "R1");
    rd(8'h08, "R1 edge bits");

    // R5: tap register fields
    wr(8'h00, 32'h3F80_2A00, "R5");
    rd(8'h00, "R5 readback");
    wr(8'h00, 32'h3F80_1780, "R5");

    // R2, R3: every control slot holds 16 bits, upper half never stored
    for (int i = 0; i < 7; i++) wr(8'(i * 4), 32'hFFFF_0000 | (32'h1111 * (i + 1)), "R3");
    for (int i = 0; i < 7; i++) rd(8'(i * 4), "R2 R3 readback");

    // R7: status, hole, misaligned and out-of-map writes are dropped
    wr(8'h20, 32'hFFFF_FFFF, "R7");
    wr(8'h1C, 32'hFFFF_0000, "R7");
    wr(8'h02, 32'hFFFF_0000, "R7");
    wr(8'h19, 32'hFFFF_0000, "R7");
    wr(8'h40, 32'hFFFF_0000, "R7");
    wr(8'hFC, 32'hFFFF_0000, "R7");
    for (int i = 0; i < 7; i++) rd(8'(i * 4), "R7 unchanged");

    // R6: status combinations
    for (int s = 0; s < 4; s++) begin
      cal = s[1]; dll = s[0];
      rd(8'h20, "R6 status");
    end
    cal = 0; dll = 0;

    // R10: unmapped reads
    rd(8'h1C, "R10"); rd(8'h24, "R10"); rd(8'h05, "R10"); rd(8'hFF, "R10");

    // R9: read during write returns old value, idle cycles read zero
    cyc(8'h0C, 32'hFFFF_BEEF, 1, 1, "R9 read-during-write");
    rd(8'h0C, "R9 new value");
    cyc(8'h0C, 32'h0, 0, 0, "R9 idle zero");

    // R8: reset in mid-run
    do_reset();
    check_fields();
    rd(8'h18, "R8 mid-run reset");
    rd(8'h0C, "R8 mid-run reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule